// File: doc/BRIEF.md
# Triple-Oversampled Asynchronous Serial Receiver

This block recovers bytes from an asynchronous serial line carrying frames of one start bit, eight data bits sent least significant bit first, no parity and one stop bit. The line passes a two-flop synchronizer and is then looked at only in cycles where the `sample_tick` input is high. An external divider is expected to pulse `sample_tick` at exactly three times the bit rate. A start is recognised on the first sampled low level while the receiver is idle. From that sample on, the block takes a window of 29 samples and picks each data bit from the middle sample of its group of three.

The window ends after the second of the three stop-bit samples. The receiver is idle again for the third stop sample, so a following start bit that comes one third of a bit early is still caught. This keeps the receiver in step with a transmitter that runs slightly fast. Stop-bit samples are not checked.

Each completed byte is held behind a valid/ready handshake. A byte that completes while the previous one has not yet been taken replaces it and sets a sticky overrun flag. A write-one-to-clear input clears the flag.

Top module: `os3_uart_rx`

## Requirements
- R1: The serial input reaches the sampler through a two-stage synchronizer, and the line is sampled only in cycles with `sample_tick` high. Line activity between ticks has no effect.
- R2: While idle, a sampled low level starts a capture, and that sample counts as sample index 0. A sampled high level while idle starts nothing.
- R3: Data bit i (i = 0 to 7, bit 0 first on the line) is taken from capture sample index 3*i+4. The other two samples of each bit are ignored, as are samples 1 and 2 of the start bit.
- R4: A capture is exactly 29 samples long (indices 0 to 28). The byte completes on the tick of index 28, and the values of stop samples 27 and 28 do not affect the byte.
- R5: The tick after index 28 is already evaluated for a new start, so back-to-back 29-sample frames are each received.
- R6: `rx_valid` rises in the cycle after the completing tick, with the byte on `rx_data`. It stays high with `rx_data` unchanged until a cycle with `rx_ready` high, after which it is low, unless another byte completes.
- R7: If a byte completes while `rx_valid` is high and `rx_ready` is low, `rx_overrun` becomes 1 and the new byte replaces the held one. A byte taken in the same cycle it is replaced does not set the flag.
- R8: `rx_overrun` stays set until a cycle with `overrun_clr` high. If that cycle also sets the flag, the set wins.
- R9: After reset, `rx_valid` and `rx_overrun` are 0, `rx_data` is 0 and the receiver is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_tick | input | 1 | Sample enable, three pulses per bit period |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | Byte available |
| rx_ready | input | 1 | Consumer takes the byte in this cycle |
| rx_overrun | output | 1 | Sticky overrun flag |
| overrun_clr | input | 1 | Write-one-to-clear for the overrun flag |

## Verification
The hardest case to reach is the frame that ends after only two stop samples with the next start bit already on the line. Only that case shows whether detection is re-armed on time. The bench builds each frame sample by sample and ends one third of the frames after index 28, so the next frame's start is the very next sample. Another third of the frames have flipped outer samples, high start samples 1 and 2, and low stop samples, which shows that only the middle samples matter. The clear-and-set collision is reached by raising `overrun_clr` on the completing tick of a frame that overruns.

// File: rtl/os3_uart_pkg.sv
package os3_uart_pkg;

    typedef enum logic {
        CAP_IDLE = 1'b0,
        CAP_BUSY = 1'b1
    } cap_state_e;

    // number of samples in one capture window
    function automatic int window_len(input int ovs, input int dbits, input int stops);
        return ovs * (1 + dbits) + stops;
    endfunction

    // capture index of the middle sample of data bit i
    function automatic int mid_index(input int ovs, input int i);
        return ovs * (i + 1) + ovs / 2;
    endfunction

endpackage

// File: rtl/os3_sync.sv
module os3_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic d_out
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain[0] = d_in;
        for (int i = 1; i < STAGES; i++) begin
            st_d.chain[i] = st_q.chain[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{chain: '1};
        else        st_q <= st_d;
    end

    assign d_out = st_q.chain[STAGES-1];
endmodule

// File: rtl/os3_capture.sv
module os3_capture
    import os3_uart_pkg::*;
#(
    parameter int DATA_BITS    = 8,
    parameter int OVS          = 3,
    parameter int STOP_SAMPLES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 line_s,
    output logic                 done,
    output logic [DATA_BITS-1:0] byte_out,
    output logic                 busy
);
    localparam int WINDOW = window_len(OVS, DATA_BITS, STOP_SAMPLES);
    localparam int CNT_W  = $clog2(WINDOW);
    localparam int LAST   = WINDOW - 1;

    typedef struct packed {
        cap_state_e           state;
        logic [CNT_W-1:0]     cnt;
        logic [DATA_BITS-1:0] data;
    } cap_t;

    cap_t st_d, st_q;
    logic done_c;

    always_comb begin
        st_d   = st_q;
        done_c = 1'b0;
        if (tick) begin
            case (st_q.state)
                CAP_IDLE: begin
                    if (!line_s) begin
                        st_d.state = CAP_BUSY;
                        st_d.cnt   = CNT_W'(1);
                    end
                end
                CAP_BUSY: begin
                    for (int i = 0; i < DATA_BITS; i++) begin
                        if (int'(st_q.cnt) == mid_index(OVS, i)) begin
                            st_d.data[i] = line_s;
                        end
                    end
                    if (int'(st_q.cnt) == LAST) begin
                        done_c     = 1'b1;
                        st_d.state = CAP_IDLE;
                        st_d.cnt   = '0;
                    end else begin
                        st_d.cnt = st_q.cnt + CNT_W'(1);
                    end
                end
                default: st_d.state = CAP_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{state: CAP_IDLE, cnt: '0, data: '0};
        else        st_q <= st_d;
    end

    assign done     = done_c;
    assign byte_out = st_q.data;
    assign busy     = (st_q.state == CAP_BUSY);
endmodule

// File: rtl/os3_holding.sv
module os3_holding #(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [DATA_BITS-1:0] load_data,
    input  logic                 ready,
    input  logic                 ovr_clr,
    output logic [DATA_BITS-1:0] data,
    output logic                 valid,
    output logic                 ovr
);
    typedef struct packed {
        logic                 valid;
        logic                 ovr;
        logic [DATA_BITS-1:0] data;
    } hold_t;

    hold_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.valid && ready) st_d.valid = 1'b0;
        if (ovr_clr)             st_d.ovr   = 1'b0;
        if (load) begin
            st_d.valid = 1'b1;
            st_d.data  = load_data;
            if (st_q.valid && !ready) st_d.ovr = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{valid: 1'b0, ovr: 1'b0, data: '0};
        else        st_q <= st_d;
    end

    assign data  = st_q.data;
    assign valid = st_q.valid;
    assign ovr   = st_q.ovr;
endmodule

// File: rtl/os3_uart_rx.sv
module os3_uart_rx #(
    parameter int DATA_BITS    = 8,
    parameter int OVS          = 3,
    parameter int STOP_SAMPLES = 2,
    parameter int SYNC_STAGES  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sample_tick,
    input  logic                 rx_line,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 rx_valid,
    input  logic                 rx_ready,
    output logic                 rx_overrun,
    input  logic                 overrun_clr
);
    logic                 line_s;
    logic                 frame_done;
    logic                 cap_busy;
    logic [DATA_BITS-1:0] cap_byte;

    os3_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (rx_line),
        .d_out (line_s)
    );

    os3_capture #(
        .DATA_BITS    (DATA_BITS),
        .OVS          (OVS),
        .STOP_SAMPLES (STOP_SAMPLES)
    ) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (sample_tick),
        .line_s   (line_s),
        .done     (frame_done),
        .byte_out (cap_byte),
        .busy     (cap_busy)
    );

    os3_holding #(.DATA_BITS(DATA_BITS)) u_holding (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (frame_done),
        .load_data (cap_byte),
        .ready     (rx_ready),
        .ovr_clr   (overrun_clr),
        .data      (rx_data),
        .valid     (rx_valid),
        .ovr       (rx_overrun)
    );
endmodule

// File: rtl/os3_uart_rx_chk.sv
module os3_uart_rx_chk #(
    parameter int DATA_BITS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 sample_tick,
    input logic [DATA_BITS-1:0] rx_data,
    input logic                 rx_valid,
    input logic                 rx_ready,
    input logic                 rx_overrun,
    input logic                 overrun_clr,
    input logic                 frame_done,
    input logic                 cap_busy
);
    p_done_on_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (sample_tick && cap_busy));

    p_valid_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_valid) |-> $past(frame_done));

    p_data_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ready && !frame_done) |=> (rx_valid && $stable(rx_data)));

    p_valid_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_ready && !frame_done) |=> !rx_valid);

    p_ovr_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && rx_valid && !rx_ready) |=> rx_overrun);

    p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_overrun && !overrun_clr) |=> rx_overrun);

    p_ovr_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun_clr && !(frame_done && rx_valid && !rx_ready)) |=> !rx_overrun);
endmodule

bind os3_uart_rx os3_uart_rx_chk #(.DATA_BITS(DATA_BITS)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sample_tick (sample_tick),
    .rx_data     (rx_data),
    .rx_valid    (rx_valid),
    .rx_ready    (rx_ready),
    .rx_overrun  (rx_overrun),
    .overrun_clr (overrun_clr),
    .frame_done  (frame_done),
    .cap_busy    (cap_busy)
);

// File: tb/test_os3_uart_rx.sv
`timescale 1ns/1ps
module test_os3_uart_rx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sample_tick = 1'b0;
    logic       rx_line = 1'b1;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       rx_ready = 1'b0;
    logic       rx_overrun;
    logic       overrun_clr = 1'b0;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    os3_uart_rx i_os3_uart_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .sample_tick (sample_tick),
        .rx_line     (rx_line),
        .rx_data     (rx_data),
        .rx_valid    (rx_valid),
        .rx_ready    (rx_ready),
        .rx_overrun  (rx_overrun),
        .overrun_clr (overrun_clr)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // mode 0: clean 30-sample frame; 1: 29 samples, next start follows at once;
    // 2: outer samples flipped, start samples 1,2 high, stop samples low
    function automatic bit samp(input logic [7:0] b, input int k, input int mode);
        int pos;
        bit v;
        if (k < 3) return (mode == 2 && k > 0);
        if (k < 27) begin
            pos = (k - 3) % 3;
            v = b[(k - 3) / 3];
            return (mode == 2 && pos != 1) ? ~v : v;
        end
        if (k < 29) return (mode != 2);
        return 1'b1;
    endfunction

    // one sample period: line set, settles through synchronizer, then one tick
    task automatic send_sample(input bit v, input bit clr_on_tick);
        @(negedge clk);
        rx_line = v;
        repeat (3) @(negedge clk);
        sample_tick = 1'b1;
        overrun_clr = clr_on_tick;
        @(negedge clk);
        sample_tick = 1'b0;
        overrun_clr = 1'b0;
    endtask

    task automatic send_frame(input logic [7:0] b, input int mode, input bit clr_last);
        int n;
        n = (mode == 1) ? 29 : 30;
        for (int k = 0; k < n; k++) send_sample(samp(b, k, mode), clr_last && (k == 28));
    endtask

    task automatic take_byte();
        @(negedge clk);
        rx_ready = 1'b1;
        @(negedge clk);
        rx_ready = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        check(rx_valid == 1'b0, "R9 valid", int'(rx_valid), 0);
        check(rx_overrun == 1'b0, "R9 overrun", int'(rx_overrun), 0);
        check(rx_data == 8'h00, "R9 data", int'(rx_data), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: low line without ticks must not start a capture
        rx_line = 1'b0;
        repeat (60) @(negedge clk);
        rx_line = 1'b1;
        repeat (5) @(negedge clk);
        check(rx_valid == 1'b0, "R1 no tick no capture", int'(rx_valid), 0);
        // R2: idle high samples start nothing
        for (int k = 0; k < 40; k++) send_sample(1'b1, 1'b0);
        check(rx_valid == 1'b0, "R2 idle high", int'(rx_valid), 0);
        send_frame(8'hA5, 0, 1'b0);
        check(rx_valid == 1'b1, "R1 clean after tickless low", int'(rx_valid), 1);
        check(rx_data == 8'hA5, "R1 data", int'(rx_data), 'hA5);
        take_byte();

        // R3 R4 R5: sweep all byte values through three frame shapes
        for (int b = 0; b < 256; b++) begin
            int mode;
            mode = b % 3;
            send_frame(8'(b), mode, 1'b0);
            check(rx_valid == 1'b1, (mode == 1) ? "R5 valid short frame" : "R4 valid",
                  int'(rx_valid), 1);
            check(rx_data == 8'(b), (mode == 2) ? "R3 middle sample" : "R3 data",
                  int'(rx_data), b);
            check(rx_overrun == 1'b0, "R7 no overrun when taken", int'(rx_overrun), 0);
            take_byte();
            check(rx_valid == 1'b0, "R6 valid drops after ready", int'(rx_valid), 0);
        end
        // finish the last short-frame gap with idle
        send_sample(1'b1, 1'b0);
        check(rx_valid == 1'b0, "R5 no spurious byte", int'(rx_valid), 0);

        // R6: valid and data hold while not taken
        send_frame(8'h5A, 0, 1'b0);
        repeat (20) @(negedge clk);
        check(rx_valid == 1'b1, "R6 valid held", int'(rx_valid), 1);
        check(rx_data == 8'h5A, "R6 data held", int'(rx_data), 'h5A);
        // R7: overrun replaces byte and sets flag
        send_frame(8'hC3, 1, 1'b0);
        check(rx_overrun == 1'b1, "R7 overrun set", int'(rx_overrun), 1);
        check(rx_data == 8'hC3, "R7 newest byte kept", int'(rx_data), 'hC3);
        send_frame(8'h0F, 0, 1'b0);
        check(rx_data == 8'h0F, "R7 second overrun data", int'(rx_data), 'h0F);
        take_byte();
        repeat (10) @(negedge clk);
        check(rx_overrun == 1'b1, "R8 sticky after take", int'(rx_overrun), 1);
        // R8: clear
        @(negedge clk); overrun_clr = 1'b1;
        @(negedge clk); overrun_clr = 1'b0;
        check(rx_overrun == 1'b0, "R8 cleared", int'(rx_overrun), 0);
        // R8: clear on same cycle as a new overrun - set wins
        send_frame(8'h11, 0, 1'b0);
        send_frame(8'h22, 0, 1'b1);
        check(rx_overrun == 1'b1, "R8 set beats clear", int'(rx_overrun), 1);
        check(rx_data == 8'h22, "R7 data on collision", int'(rx_data), 'h22);
        take_byte();
        @(negedge clk); overrun_clr = 1'b1;
        @(negedge clk); overrun_clr = 1'b0;
        // R7: ready held high - back-to-back bytes never overrun
        rx_ready = 1'b1;
        send_frame(8'h81, 1, 1'b0);
        send_frame(8'h7E, 0, 1'b0);
        repeat (2) @(negedge clk);
        check(rx_overrun == 1'b0, "R7 ready high no overrun", int'(rx_overrun), 0);
        check(rx_valid == 1'b0, "R6 consumed with ready high", int'(rx_valid), 0);
        check(rx_data == 8'h7E, "R6 last data", int'(rx_data), 'h7E);
        rx_ready = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule